// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI master read and write an 8-bit register file of up to 256 locations. The master frames each access with an active-low chip select. The access opens with a command byte and an address byte. Data bytes follow. The command byte says whether the access reads or writes, and whether the address steps forward after each data byte. On a write the block issues one write strobe per accepted data byte. On a read it issues a read strobe and shifts the returned byte out on MISO, starting with the first data byte.

The SPI pins are oversampled by the system clock through synchronizers. Every bit boundary comes from an SCK edge, so a transfer does not depend on the master's rate or on the system clock phase. The system clock only has to be fast enough: each SCK half-period must span at least six system clock cycles. All four clock polarity and phase combinations are selected by two static inputs. The register file itself sits outside the block and answers a read strobe one cycle later, as a block RAM does.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, miso, reg_wr_en and reg_rd_en are all 0.
- R2: Bytes on MOSI are taken MSB first. The command byte (byte 0) has bit 7 as the read flag (1 = read, 0 = write) and bit 0 as the burst flag. Byte 1 holds the register address.
- R3: A write access produces exactly one reg_wr_en pulse for the first data byte, with reg_wr_addr equal to byte 1 and reg_wr_data equal to byte 2.
- R4: In a write without burst, data bytes after the first produce no write strobe.
- R5: In a burst write, data byte k (counting from 0) is written to address byte1 + k. The address wraps from the top address to 0.
- R6: In a read, the first data byte period carries, MSB first on MISO, the register value at the address given in byte 1.
- R7: In a burst read, data byte k on MISO carries the register at address byte1 + k, with wrap.
- R8: In a read without burst, every data byte period returns the same register value, and only one read strobe is issued.
- R9: R2 to R8 hold in all four SPI modes. CPHA = 0 samples on the leading SCK edge and CPHA = 1 on the trailing edge, where the leading edge is the one that leaves the CPOL idle level.
- R10: Raising cs_n before a byte is complete discards that partial byte without a strobe. The next access starts again with a command byte.
- R11: MISO is 0 whenever cs_n is high, and during the two header bytes of any access.
- R12: During a read, MOSI data bytes cause no write strobe. During a write, no read strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cpol | input | 1 | SCK idle level (static during a transfer) |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| sck | input | 1 | SPI clock from master |
| cs_n | input | 1 | Active-low chip select framing an access |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master, 0 when not selected |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | ADDR_W | Write address |
| reg_wr_data | output | DATA_W | Write data |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rd_addr | output | ADDR_W | Read address |
| reg_rd_data | input | DATA_W | Read data, valid the cycle after reg_rd_en |

## Verification
The checker watches several rules on every cycle. MISO falls quiet once select is dropped. No strobe is issued while deselected. Writes and reads never mix within one access. A non-burst access issues at most one strobe. Consecutive burst strobes step the address by one with wrap. Only the bench's scenarios can show the rest. These are bit order and header decoding, the actual values written and shifted back out in each of the four SPI modes, the abort of a partial byte followed by a clean fresh access, and repeated data on non-burst reads.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  // Position of the flags inside the command byte
  localparam int CMD_READ_BIT  = 7;
  localparam int CMD_BURST_BIT = 0;

  // Which byte of an access is being received
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cpol,
  input  logic cpha,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic cs_act,
  output logic sample_stb,
  output logic shift_stb,
  output logic mosi_bit
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sck_p, cs_p, mosi_p;
  logic                   sck_q;
  logic                   sck_norm, lead, trail;

  // Synchronizer chains, all pins delayed alike so MOSI lines up with SCK
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sck_q  <= 1'b0;
    end else begin
      sck_p  <= {sck_p[SYNC_STAGES-2:0], sck};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
      sck_q  <= sck_norm;
    end
  end

  // Normalise so the idle level is always 0: leading edge is then a rise
  assign sck_norm   = sck_p[TOP] ^ cpol;
  assign lead       = sck_norm & ~sck_q;
  assign trail      = ~sck_norm & sck_q;
  assign cs_act     = ~cs_p[TOP];
  assign sample_stb = cs_act & (cpha ? trail : lead);
  assign shift_stb  = cs_act & (cpha ? lead : trail);
  assign mosi_bit   = mosi_p[TOP];

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sample_stb,
  input  logic              shift_stb,
  input  logic              mosi_bit,
  input  logic [DATA_W-1:0] tx_load,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              miso
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sr, tx_sr, rx_next;

  assign rx_next = {rx_sr[DATA_W-2:0], mosi_bit};

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sample_stb) begin
        rx_sr <= rx_next;
        if (bit_cnt == LAST) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
          rx_byte   <= rx_next;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      // A drive edge with the counter at 0 puts out the first bit of a byte
      if (shift_stb) begin
        if (bit_cnt == '0) tx_sr <= tx_load;
        else               tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign miso = tx_sr[DATA_W-1];

endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] reg_rd_data,
  output logic [DATA_W-1:0] tx_load,
  output logic              burst,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_rd_addr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  phase_e            phase;
  logic              is_read;
  logic              data_seen;
  logic              rd_pend;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] addr_inc;

  assign addr_inc = addr + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_CMD;
      is_read     <= 1'b0;
      burst       <= 1'b0;
      data_seen   <= 1'b0;
      rd_pend     <= 1'b0;
      addr        <= '0;
      tx_load     <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
      reg_rd_en   <= 1'b0;
      reg_rd_addr <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      rd_pend   <= reg_rd_en;
      if (rd_pend) tx_load <= reg_rd_data;
      if (!cs_act) begin
        phase     <= PH_CMD;
        data_seen <= 1'b0;
        rd_pend   <= 1'b0;
        tx_load   <= '0;
      end else if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            is_read <= rx_byte[CMD_READ_BIT];
            burst   <= rx_byte[CMD_BURST_BIT];
            phase   <= PH_ADDR;
          end
          PH_ADDR: begin
            addr  <= rx_byte[ADDR_W-1:0];
            phase <= PH_DATA;
            if (is_read) begin
              reg_rd_en   <= 1'b1;
              reg_rd_addr <= rx_byte[ADDR_W-1:0];
            end
          end
          default: begin
            data_seen <= 1'b1;
            if (is_read) begin
              // Non-burst read keeps the fetched byte and resends it
              if (burst) begin
                addr        <= addr_inc;
                reg_rd_en   <= 1'b1;
                reg_rd_addr <= addr_inc;
              end
            end else if (!data_seen || burst) begin
              reg_wr_en   <= 1'b1;
              reg_wr_addr <= addr;
              reg_wr_data <= rx_byte;
              if (burst) addr <= addr_inc;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_rd_addr,
  input  logic [DATA_W-1:0] reg_rd_data
);

  logic              cs_act, sample_stb, shift_stb, mosi_bit;
  logic              byte_done, burst;
  logic [DATA_W-1:0] rx_byte, tx_load;

  spi_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .cpol       (cpol),
    .cpha       (cpha),
    .sck        (sck),
    .cs_n       (cs_n),
    .mosi       (mosi),
    .cs_act     (cs_act),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .mosi_bit   (mosi_bit)
  );

  spi_byte_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .mosi_bit   (mosi_bit),
    .tx_load    (tx_load),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .miso       (miso)
  );

  spi_txn_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cs_act      (cs_act),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .reg_rd_data (reg_rd_data),
    .tx_load     (tx_load),
    .burst       (burst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .reg_rd_en   (reg_rd_en),
    .reg_rd_addr (reg_rd_addr)
  );

endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              burst,
  input logic              miso,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_wr_addr,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_rd_addr
);

  logic              wr_seen, rd_seen;
  logic [ADDR_W-1:0] last_wr, last_rd;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      wr_seen <= 1'b0;
      rd_seen <= 1'b0;
      last_wr <= '0;
      last_rd <= '0;
    end else begin
      if (reg_wr_en) begin wr_seen <= 1'b1; last_wr <= reg_wr_addr; end
      if (reg_rd_en) begin rd_seen <= 1'b1; last_rd <= reg_rd_addr; end
    end
  end

  p_miso_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso);

  p_idle_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!reg_wr_en && !reg_rd_en));

  p_single_write_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !burst) |-> !wr_seen);

  p_single_read_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && !burst) |-> !rd_seen);

  p_wr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && wr_seen) |-> (reg_wr_addr == ADDR_W'(last_wr + 1'b1)));

  p_rd_step_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && rd_seen) |-> (reg_rd_addr == ADDR_W'(last_rd + 1'b1)));

  p_no_mix_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en |-> !rd_seen) and (reg_rd_en |-> !wr_seen));

endmodule

bind spi_reg_port spi_reg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_act      (cs_act),
  .burst       (burst),
  .miso        (miso),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .reg_rd_en   (reg_rd_en),
  .reg_rd_addr (reg_rd_addr)
);

// File: tb/test_spi_reg_port.sv
module test_spi_reg_port;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cpol = 1'b0, cpha = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, reg_wr_en, reg_rd_en;
  logic [AW-1:0] reg_wr_addr, reg_rd_addr;
  logic [DW-1:0] reg_wr_data, reg_rd_data;

  always #2 clk = ~clk;

  spi_reg_port #(.ADDR_W(AW), .DATA_W(DW)) i_spi_reg_port (
    .clk(clk), .rst(rst), .cpol(cpol), .cpha(cpha), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data)
  );

  // Register file model: one-cycle read latency
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] shd [0:(1<<AW)-1];
  always @(posedge clk) begin
    if (reg_wr_en) mem[reg_wr_addr] <= reg_wr_data;
    if (reg_rd_en) reg_rd_data <= mem[reg_rd_addr];
  end

  int n_tests = 0, n_fail = 0;
  int wr_count = 0, rd_count = 0;
  logic [AW+DW-1:0] exp_q [$];
  logic [7:0] txb [8];
  logic [7:0] rxb [8];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_rd_en) rd_count++;
      if (reg_wr_en) begin
        wr_count++;
        if (exp_q.size() == 0) begin
          check("R4/R10/R12 unexpected write", {reg_wr_addr, reg_wr_data}, 32'hFFFF_FFFF);
        end else begin
          check("R3/R5 write addr+data", {reg_wr_addr, reg_wr_data}, exp_q.pop_front());
        end
      end
    end
  end

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  // Master driver: nb full bytes then pbits extra bits before deselect
  task automatic spi_xfer(input logic cp, input logic ch, input int nb, input int pbits);
    int total;
    cpol = cp; cpha = ch; sck = cp;
    half(); half();
    cs_n = 1'b0;
    half();
    total = (pbits > 0) ? nb + 1 : nb;
    for (int b = 0; b < total; b++) begin
      int nbits;
      nbits = (b < nb) ? 8 : pbits;
      rxb[b] = '0;
      for (int k = 0; k < nbits; k++) begin
        if (!ch) begin
          mosi = txb[b][7-k];
          half();
          rxb[b] = {rxb[b][6:0], miso};
          sck = ~cp;
          half();
          sck = cp;
        end else begin
          sck = ~cp;
          mosi = txb[b][7-k];
          half();
          rxb[b] = {rxb[b][6:0], miso};
          sck = cp;
          half();
        end
      end
    end
    half();
    cs_n = 1'b1;
    half(); half();
  endtask

  task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    shd[a] = d;
  endtask

  logic done = 1'b0;

  initial begin
    int w0, r0;
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i] = 8'(i * 7 + 3);
      shd[i] = 8'(i * 7 + 3);
    end
    reg_rd_data = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 miso", miso, 0);
    check("R1 wr_en", reg_wr_en, 0);
    check("R1 rd_en", reg_rd_en, 0);

    // R2 R3: mode 0 single write
    txb[0] = 8'h00; txb[1] = 8'h12; txb[2] = 8'hA5;
    expect_wr(8'h12, 8'hA5);
    spi_xfer(0, 0, 3, 0);
    check("R3 write queue drained", exp_q.size(), 0);

    // R4: non-burst write, extra bytes ignored
    w0 = wr_count;
    txb[0] = 8'h00; txb[1] = 8'h40; txb[2] = 8'h11; txb[3] = 8'h22; txb[4] = 8'h33;
    expect_wr(8'h40, 8'h11);
    spi_xfer(0, 0, 5, 0);
    check("R4 one write only", wr_count - w0, 1);
    check("R4 queue drained", exp_q.size(), 0);

    // R5 R9: mode 3 burst write with wrap
    txb[0] = 8'h01; txb[1] = 8'hFE;
    txb[2] = 8'hC1; txb[3] = 8'hC2; txb[4] = 8'hC3; txb[5] = 8'hC4;
    expect_wr(8'hFE, 8'hC1); expect_wr(8'hFF, 8'hC2);
    expect_wr(8'h00, 8'hC3); expect_wr(8'h01, 8'hC4);
    r0 = rd_count;
    spi_xfer(1, 1, 6, 0);
    check("R5 burst writes drained", exp_q.size(), 0);
    check("R12 no read strobe in write", rd_count - r0, 0);

    // R6 R9 R11: mode 1 read
    txb[0] = 8'h80; txb[1] = 8'h12; txb[2] = 8'h00;
    spi_xfer(0, 1, 3, 0);
    check("R11 header byte0 miso", rxb[0], 0);
    check("R11 header byte1 miso", rxb[1], 0);
    check("R6 read data mode1", rxb[2], shd[8'h12]);
    @(negedge clk);
    check("R11 miso idle after cs", miso, 0);

    // R7 R9: mode 2 burst read across wrap
    txb[0] = 8'h81; txb[1] = 8'hFF; txb[2] = 0; txb[3] = 0; txb[4] = 0;
    spi_xfer(1, 0, 5, 0);
    check("R7 burst read 0", rxb[2], shd[8'hFF]);
    check("R7 burst read 1", rxb[3], shd[8'h00]);
    check("R7 burst read 2", rxb[4], shd[8'h01]);

    // R6 mode 0 read of burst-written location
    txb[0] = 8'h80; txb[1] = 8'hFE; txb[2] = 0;
    spi_xfer(0, 0, 3, 0);
    check("R6 read data mode0", rxb[2], 8'hC1);

    // R10: abort mid data byte, then fresh access
    w0 = wr_count;
    txb[0] = 8'h00; txb[1] = 8'h30; txb[2] = 8'hC3;
    spi_xfer(0, 0, 2, 4);
    check("R10 no write on abort", wr_count - w0, 0);
    txb[0] = 8'h00; txb[1] = 8'h31; txb[2] = 8'h3C;
    expect_wr(8'h31, 8'h3C);
    spi_xfer(1, 1, 3, 0);
    check("R10 fresh header works", wr_count - w0, 1);
    check("R10 queue drained", exp_q.size(), 0);

    // R8 R12: non-burst read with junk MOSI
    w0 = wr_count; r0 = rd_count;
    txb[0] = 8'h80; txb[1] = 8'h31; txb[2] = 8'hFF; txb[3] = 8'hFF; txb[4] = 8'hFF;
    spi_xfer(1, 1, 5, 0);
    check("R8 repeat 0", rxb[2], 8'h3C);
    check("R8 repeat 1", rxb[3], 8'h3C);
    check("R8 repeat 2", rxb[4], 8'h3C);
    check("R8 one read strobe", rd_count - r0, 1);
    check("R12 no write during read", wr_count - w0, 0);
    check("R12 register unchanged", mem[8'h31], 8'h3C);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule